// File: doc/BRIEF.md
# SPI Flash Identification Reader

This block is the master end of a four-wire SPI link to a serial flash. A single-cycle start request, taken only while the block is idle, makes it pull chip select low, shift out the identification opcode 0x9F and then clock in between one and four response bytes. The captured bytes are split into a manufacturer code, a sixteen-bit device code and an extended-information length. A match flag reports whether the manufacturer code equals a value fixed at build time.

The serial clock is made from the system clock by a divider whose half-period is a parameter. It rests high between transactions. Command bits change on its falling edge and the response is sampled on its rising edge. The response starts in the bit slot right after the last opcode bit, with no dummy cycles. Chip select can be released after any number of response bytes, so software that only needs the manufacturer code can keep the transaction short.

Top module: `spi_id_reader`

## Requirements
- R1: While reset is held and after it is released, cs_n and sclk are 1, and mosi, busy, done, mfr_id, dev_id, ext_len and id_match are 0.
- R2: A start request in an idle cycle drives cs_n low at the next clock edge while sclk stays high, and sclk then stays high for one half-period.
- R3: The opcode 0x9F is sent on mosi most significant bit first. mosi changes only together with a falling sclk edge and is 0 at all other times.
- R4: Each half of an sclk period lasts exactly CLK_DIV system clock cycles.
- R5: miso is sampled at each rising sclk edge. Response bit 0 (the MSB of byte 1) is sampled in the bit slot that directly follows the eighth opcode bit.
- R6: The count input nbytes selects 1 to 4 response bytes. A value of 0 counts as 1 and values 5 to 7 count as 4. The count is taken when the start request is accepted.
- R7: Byte 1 goes to mfr_id, byte 2 to dev_id[15:8], byte 3 to dev_id[7:0] and byte 4 to ext_len. Fields for bytes that were not read are 0.
- R8: After the last response bit, cs_n rises at the same edge at which sclk falls. sclk rises again one half-period later and the block is then idle.
- R9: done is high for exactly the one cycle in which cs_n has just risen. The output fields take their new values in that same cycle and hold them until the next done.
- R10: busy is high from the cycle after start is accepted until the trailing half-period ends. While busy is low, cs_n and sclk are both 1.
- R11: A start request while busy is ignored. Only a request seen in an idle cycle begins a new transaction.
- R12: id_match becomes 1 together with done when the new mfr_id equals EXP_MFR (default 0x1F), and becomes 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin one identification read |
| nbytes | input | 3 | Number of response bytes to capture |
| miso | input | 1 | Serial data from the flash |
| cs_n | output | 1 | Chip select to the flash, active low |
| sclk | output | 1 | Serial clock, rests high |
| mosi | output | 1 | Serial data to the flash |
| busy | output | 1 | A transaction is in progress |
| done | output | 1 | One-cycle pulse at the end of a transaction |
| mfr_id | output | 8 | Captured manufacturer code |
| dev_id | output | 16 | Captured device code |
| ext_len | output | 8 | Captured extended-information length |
| id_match | output | 1 | mfr_id equals EXP_MFR |

## Verification
Two things can fall in the same cycle: the end of one transaction, where busy drops in the cycle after the trailing half, and a start request that is still asserted. The bench holds start high across whole transactions. A correct design must ignore the request while busy and then begin a new read in the first idle cycle. A behavioural timeline model predicts every pin cycle by cycle and counts the done pulses, which must match that model exactly. The model also predicts the boundary where the release of chip select and the update of the fields happen at the same edge.

// File: rtl/spi_id_reader.sv
module spi_id_reader #(
  parameter int          CLK_DIV = 4,
  parameter logic [7:0]  EXP_MFR = 8'h1F,
  parameter logic [7:0]  OPCODE  = 8'h9F
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [2:0]  nbytes,
  input  logic        miso,
  output logic        cs_n,
  output logic        sclk,
  output logic        mosi,
  output logic        busy,
  output logic        done,
  output logic [7:0]  mfr_id,
  output logic [15:0] dev_id,
  output logic [7:0]  ext_len,
  output logic        id_match
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_SHIFT, S_STOP} st_t;

  st_t         st;
  logic [CW-1:0] cnt;
  logic [5:0]  bidx, last_idx, nxt;
  logic [2:0]  nb_q, nb_c;
  logic [31:0] rx, aligned;
  logic [5:0]  sh;
  logic        tick;

  assign tick    = (cnt == CW'(CLK_DIV - 1));
  assign nb_c    = (nbytes == 3'd0) ? 3'd1 : ((nbytes > 3'd4) ? 3'd4 : nbytes);
  assign sh      = {3'd4 - nb_q, 3'b000};
  assign aligned = rx << sh;
  assign nxt     = bidx + 6'd1;
  assign busy    = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      bidx     <= '0;
      last_idx <= '0;
      nb_q     <= 3'd1;
      rx       <= '0;
      cs_n     <= 1'b1;
      sclk     <= 1'b1;
      mosi     <= 1'b0;
      done     <= 1'b0;
      mfr_id   <= '0;
      dev_id   <= '0;
      ext_len  <= '0;
      id_match <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == S_IDLE) cnt <= '0;
      else              cnt <= tick ? '0 : cnt + CW'(1);
      case (st)
        S_IDLE: if (start) begin
          st       <= S_SETUP;
          cs_n     <= 1'b0;
          nb_q     <= nb_c;
          last_idx <= {nb_c, 3'b111};
          bidx     <= '0;
          rx       <= '0;
        end
        S_SETUP: if (tick) begin
          sclk <= 1'b0;
          mosi <= OPCODE[7];
          st   <= S_SHIFT;
        end
        S_SHIFT: if (tick) begin
          if (!sclk) begin
            sclk <= 1'b1;
            if (bidx >= 6'd8) rx <= {rx[30:0], miso};
          end else if (bidx == last_idx) begin
            sclk     <= 1'b0;
            cs_n     <= 1'b1;
            mosi     <= 1'b0;
            done     <= 1'b1;
            st       <= S_STOP;
            mfr_id   <= aligned[31:24];
            dev_id   <= aligned[23:8];
            ext_len  <= aligned[7:0];
            id_match <= (aligned[31:24] == EXP_MFR);
          end else begin
            bidx <= nxt;
            sclk <= 1'b0;
            mosi <= (nxt < 6'd8) ? OPCODE[~nxt[2:0]] : 1'b0;
          end
        end
        S_STOP: if (tick) begin
          sclk <= 1'b1;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_id_reader_chk.sv
module spi_id_reader_chk #(
  parameter logic [7:0] EXP_MFR = 8'h1F
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       sclk,
  input logic       mosi,
  input logic       busy,
  input logic       done,
  input logic [7:0] mfr_id,
  input logic       id_match
);
  AST_CS_LOW_WITH_SCLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n) $fell(cs_n) |-> sclk); // R2
  AST_MOSI_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n) !$stable(mosi) |-> $fell(sclk)); // R3
  AST_CS_RELEASE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n) $rose(cs_n) |-> $fell(sclk)); // R8
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
  AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) done |-> $rose(cs_n)); // R9
  AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(mfr_id) && $stable(id_match)); // R9
  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> cs_n && sclk); // R10
  AST_MATCH_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n) done |-> (id_match == (mfr_id == EXP_MFR))); // R12
endmodule

bind spi_id_reader spi_id_reader_chk #(.EXP_MFR(EXP_MFR)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
  .busy(busy), .done(done), .mfr_id(mfr_id), .id_match(id_match)
);

// File: tb/spi_id_reader_bench.sv
module spi_id_reader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 2;
  localparam logic [7:0] OPC = 8'h9F;
  localparam logic [7:0] EXP = 8'h1F;

  logic clk = 0, rst_n = 0, start = 0, miso = 0;
  logic [2:0] nbytes = 3'd4;
  logic cs_n, sclk, mosi, busy, done, id_match;
  logic [7:0] mfr_id, ext_len;
  logic [15:0] dev_id;

  int checks = 0, fails = 0;
  bit finished = 0;

  bit active = 0;
  int n = 0, nbm = 1, bits = 16;
  logic [31:0] resp_cur = 0, resp_next = 0;
  logic [7:0] e_mfr = 0, e_ext = 0;
  logic [15:0] e_dev = 0;
  logic e_match = 0;
  int dones_seen = 0, dones_model = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_id_reader #(.CLK_DIV(DIV), .EXP_MFR(EXP)) u_spi_id_reader (
    .clk(clk), .rst_n(rst_n), .start(start), .nbytes(nbytes), .miso(miso),
    .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .busy(busy), .done(done),
    .mfr_id(mfr_id), .dev_id(dev_id), .ext_len(ext_len), .id_match(id_match)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int clampn(input logic [2:0] v);
    if (v == 0) return 1;
    if (v > 4) return 4;
    return int'(v);
  endfunction

  task automatic step();
    logic st_b;
    logic [2:0] nb_b;
    int h, i;
    logic x_cs, x_sclk, x_mosi, x_busy, x_done;
    logic [31:0] keep;
    st_b = start & rst_n;
    nb_b = nbytes;
    @(posedge clk);
    #1;
    if (active) begin
      n++;
      if (n == (2*bits + 2)*DIV) active = 0;
    end else if (st_b) begin
      active = 1; n = 0; nbm = clampn(nb_b); bits = 8 + 8*nbm; resp_cur = resp_next;
    end
    x_cs = 1; x_sclk = 1; x_mosi = 0; x_busy = 0; x_done = 0; miso = 0;
    if (active) begin
      h = n / DIV;
      x_busy = 1;
      x_cs = (h > 2*bits);
      if (h == 0) x_sclk = 1;
      else if (h <= 2*bits) x_sclk = ((h-1) % 2 == 1);
      else x_sclk = 0;
      if (h >= 1 && h <= 2*bits) begin
        i = (h-1)/2;
        if (i < 8) x_mosi = OPC[7-i];
        else miso = resp_cur[31-(i-8)];
      end
      if (n == (2*bits+1)*DIV) begin
        x_done = 1;
        dones_model++;
        keep = resp_cur & (32'hFFFF_FFFF << (8*(4-nbm)));
        e_mfr = keep[31:24]; e_dev = keep[23:8]; e_ext = keep[7:0];
        e_match = (e_mfr == EXP);
      end
    end
    #(CLK_PERIOD/2 - 2);
    if (done) dones_seen++;
    chk("R8", "cs_n", cs_n, x_cs);
    chk("R4", "sclk", sclk, x_sclk);
    chk("R3", "mosi", mosi, x_mosi);
    chk("R10", "busy", busy, x_busy);
    chk("R9", "done", done, x_done);
    chk("R7", "mfr_id", mfr_id, e_mfr);
    chk("R7", "dev_id", dev_id, e_dev);
    chk("R7", "ext_len", ext_len, e_ext);
    chk("R12", "id_match", id_match, e_match);
  endtask

  task automatic txn(input logic [2:0] nb, input logic [31:0] r);
    resp_next = r; nbytes = nb; start = 1;
    step();
    start = 0;
    while (active) step();
    step();
  endtask

  initial begin
    repeat (3) step();
    chk("R1", "cs_n in reset", cs_n, 1);
    chk("R1", "sclk in reset", sclk, 1);
    chk("R1", "fields in reset", {mfr_id, dev_id, ext_len}, 0);
    rst_n = 1;
    step();
    chk("R1", "busy after reset", busy, 0);

    txn(3'd4, 32'h1F_25_86_00);
    chk("R5", "full id", {mfr_id, dev_id, ext_len}, 32'h1F258600);
    chk("R12", "match", id_match, 1);

    txn(3'd1, 32'h1F_AA_BB_CC);
    chk("R6", "one byte fields", {mfr_id, dev_id, ext_len}, 32'h1F000000);

    txn(3'd2, 32'hC2_20_18_00);
    chk("R6", "two byte fields", {mfr_id, dev_id, ext_len}, 32'hC2200000);
    chk("R12", "mismatch", id_match, 0);

    txn(3'd0, 32'h5A_11_22_33);
    chk("R6", "zero counts as one", {mfr_id, dev_id, ext_len}, 32'h5A000000);

    txn(3'd7, 32'h1F_81_7E_A5);
    chk("R6", "seven counts as four", {mfr_id, dev_id, ext_len}, 32'h1F817EA5);

    txn(3'd3, 32'h80_01_FE_77);
    chk("R5", "three bytes msb first", {mfr_id, dev_id, ext_len}, 32'h8001FE00);

    dones_seen = 0; dones_model = 0;
    resp_next = 32'h1F_00_00_00; nbytes = 3'd4; start = 1;
    repeat (50) step();
    start = 0;
    while (active) step();
    step();
    chk("R11", "one read while start held", dones_seen, 1);

    dones_seen = 0; dones_model = 0;
    resp_next = 32'h3C_00_00_00; nbytes = 3'd1; start = 1;
    repeat (80) step();
    start = 0;
    while (active) step();
    step();
    chk("R11", "restart right after idle", dones_seen, 2);
    chk("R10", "model agrees on reads", dones_seen, dones_model);
    chk("R2", "idle cs_n at end", cs_n, 1);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule